// File: doc/BRIEF.md
# OR Instruction Byte-Stream Executor

This block accepts a stream of instruction bytes, one per cycle, over a valid/ready handshake. It recognises the inclusive-OR family of a classic 32-bit CISC opcode map and carries it out against an internal file of eight 32-bit registers. It reads an opcode byte first. Where the form needs one, it then reads an operand-selector byte, whose mode, register and register-or-memory fields are decoded. Last come any immediate bytes. After that it performs the OR, writes the destination register and updates a six-bit arithmetic flags register.

A mode input picks 16-bit or 32-bit operand size for the non-byte forms. The block latches this choice when it accepts each opcode byte. Only register-direct operands are handled. An opcode outside the family, a group opcode whose extension field is not 1, or a selector byte that names a memory operand ends the instruction with a one-cycle unsupported pulse. The register file and the flags are then left untouched. A read port lets the surrounding logic observe any register.

Top module: `orx_top`

## Requirements
- R1: While reset is asserted, and on release, all eight registers and the flags read 0, `inReady` is 1, and `done` and `unsupported` are 0.
- R2: Opcode 0x0C ORs one immediate byte into bits 7:0 of register 0. Opcode 0x0D ORs an immediate of 2 bytes (16-bit mode) or 4 bytes (32-bit mode) into register 0. Immediates arrive least significant byte first.
- R3: Opcodes 0x80 and 0x81 are executed only when the selector reg field (bits 5:3) is 1. They OR an immediate into the register named by the selector bits 2:0. The immediate is 1 byte for 0x80 (byte operand) and the full operand size for 0x81.
- R4: Opcode 0x83 with reg field 1 takes a single immediate byte. It sign-extends that byte to 16 or 32 bits before the OR.
- R5: Opcodes 0x08/0x09 OR the register named by bits 5:3 into the one named by bits 2:0. Opcodes 0x0A/0x0B OR bits 2:0 into bits 5:3. 0x08/0x0A are byte forms, and 0x09/0x0B use the operand size.
- R6: Byte register codes 0..3 address bits 7:0 of registers 0..3, and codes 4..7 address bits 15:8 of registers 0..3. Byte writes leave the other 24 bits unchanged. 16-bit writes leave bits 31:16 unchanged.
- R7: `flags` holds {OF,SF,ZF,AF,PF,CF} in bits 5..0. After an OR, CF, OF and AF are 0. ZF is set when the result at the operand width is zero. SF is the result's top bit at that width. PF is set when result bits 7:0 hold an even number of ones. The flags change only together with `done`.
- R8: When the last byte of an instruction is accepted at edge k, `inReady` is 0 for the next two cycles. The register and flags update becomes visible after edge k+2, when `inReady` returns to 1.
- R9: An opcode outside {0x08,0x09,0x0A,0x0B,0x0C,0x0D,0x80,0x81,0x83} raises `unsupported` for the one cycle after that byte is accepted. So does a group opcode whose reg field is not 1, or a selector byte whose bits 7:6 are not 11. The registers and flags are not changed, and the next byte accepted is treated as an opcode.
- R10: `done` is high for exactly one cycle per completed update, together with the new register and flags values, and is never high together with `unsupported`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 selects 32-bit operand size, 0 selects 16-bit; sampled with each opcode byte |
| inValid | input | 1 | Instruction byte on `inByte` is valid |
| inByte | input | 8 | Instruction byte |
| inReady | output | 1 | Block can accept a byte this cycle |
| done | output | 1 | One-cycle pulse: register and flags update completed |
| unsupported | output | 1 | One-cycle pulse: instruction rejected |
| rdIdx | input | 3 | Register read select |
| rdData | output | 32 | Contents of register `rdIdx` |
| flags | output | 6 | {OF,SF,ZF,AF,PF,CF} |

## Verification
The byte stream mixes every opcode form in both operand sizes, with the valid signal gapped every fifth cycle so that handshake stalls fall inside opcode, selector and immediate phases. The accumulator and group immediates use top-bit-set values, which separates sign extension from zero extension and 16-bit from 32-bit immediate length. The register-to-register forms are run in both directions, which exposes a swapped source and destination. Byte forms naming codes 4..7 separate high-byte from low-byte addressing. A zero-result OR and odd- and even-parity results exercise every flag. Rejected opcodes, group extensions other than 1 and memory-mode selectors are each followed by a valid instruction, so the bench shows whether the block resynchronises on the next opcode.

// File: rtl/orx_pkg.sv
package orx_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 8;
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned IMM_BYTES = XLEN / 8;
  localparam int unsigned IMM_IDX_W = $clog2(IMM_BYTES);
  localparam int unsigned CNT_W = $clog2(IMM_BYTES + 1);

  localparam logic [7:0] OP_RM_B  = 8'h08;
  localparam logic [7:0] OP_RM_V  = 8'h09;
  localparam logic [7:0] OP_REG_B = 8'h0A;
  localparam logic [7:0] OP_REG_V = 8'h0B;
  localparam logic [7:0] OP_ACC_B = 8'h0C;
  localparam logic [7:0] OP_ACC_V = 8'h0D;
  localparam logic [7:0] OP_GRP_B = 8'h80;
  localparam logic [7:0] OP_GRP_V = 8'h81;
  localparam logic [7:0] OP_GRP_S = 8'h83;
  localparam logic [2:0] GRP_OR_EXT = 3'd1;

  localparam int unsigned FL_CF = 0;
  localparam int unsigned FL_PF = 1;
  localparam int unsigned FL_AF = 2;
  localparam int unsigned FL_ZF = 3;
  localparam int unsigned FL_SF = 4;
  localparam int unsigned FL_OF = 5;
  localparam int unsigned FL_W  = 6;

  typedef enum logic [2:0] {
    ST_OPC, ST_MODRM, ST_IMM, ST_EX1, ST_EX2
  } orx_state_e;

  typedef enum logic [1:0] {
    SZ_B, SZ_W, SZ_D
  } orx_size_e;

  typedef enum logic [2:0] {
    K_ACC, K_GRP, K_GRPS, K_TO_RM, K_TO_REG
  } orx_kind_e;

  typedef struct packed {
    logic immClr;
    logic immLoad;
    logic capture;
    logic commit;
  } orx_strobe_t;

  typedef struct packed {
    orx_size_e              size;
    logic                   srcImm;
    logic                   immSext;
    logic [RIDX_W-1:0]      dstSel;
    logic [RIDX_W-1:0]      srcSel;
    logic [IMM_IDX_W-1:0]   immPos;
  } orx_opd_t;
endpackage

// File: rtl/orx_ctrl.sv
module orx_ctrl
  import orx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode32,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  output logic        inReady,
  output logic        done,
  output logic        unsupported,
  output orx_strobe_t strb,
  output orx_opd_t    opd
);
  orx_state_e        state;
  orx_kind_e         kindQ;
  orx_size_e         sizeQ;
  logic              srcImmQ;
  logic              sextQ;
  logic [RIDX_W-1:0] dstQ;
  logic [RIDX_W-1:0] srcQ;
  logic [CNT_W-1:0]  immLenQ;
  logic [CNT_W-1:0]  immCntQ;
  logic              doneQ;
  logic              unsQ;

  logic              accept;
  logic              opValid;
  orx_kind_e         opKind;
  logic              opByte;
  orx_size_e         opSize;
  logic [1:0]        selMod;
  logic [2:0]        selReg;
  logic [RIDX_W-1:0] selRm;
  logic              selBad;

  function automatic logic [CNT_W-1:0] lenOf(orx_size_e s);
    case (s)
      SZ_D:    return CNT_W'(IMM_BYTES);
      SZ_W:    return CNT_W'(IMM_BYTES / 2);
      default: return CNT_W'(1);
    endcase
  endfunction

  assign inReady = (state == ST_OPC) || (state == ST_MODRM) || (state == ST_IMM);
  assign accept  = inValid && inReady;

  always_comb begin
    opValid = 1'b1;
    opKind  = K_ACC;
    opByte  = 1'b0;
    case (inByte)
      OP_ACC_B: begin opKind = K_ACC;    opByte = 1'b1; end
      OP_ACC_V: begin opKind = K_ACC;                   end
      OP_GRP_B: begin opKind = K_GRP;    opByte = 1'b1; end
      OP_GRP_V: begin opKind = K_GRP;                   end
      OP_GRP_S: begin opKind = K_GRPS;                  end
      OP_RM_B:  begin opKind = K_TO_RM;  opByte = 1'b1; end
      OP_RM_V:  begin opKind = K_TO_RM;                 end
      OP_REG_B: begin opKind = K_TO_REG; opByte = 1'b1; end
      OP_REG_V: begin opKind = K_TO_REG;                end
      default:  opValid = 1'b0;
    endcase
    if (opByte)      opSize = SZ_B;
    else if (mode32) opSize = SZ_D;
    else             opSize = SZ_W;
  end

  assign selMod = inByte[7:6];
  assign selReg = inByte[5:3];
  assign selRm  = inByte[2:0];
  assign selBad = (selMod != 2'b11) ||
                  (((kindQ == K_GRP) || (kindQ == K_GRPS)) && (selReg != GRP_OR_EXT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OPC;
      kindQ   <= K_ACC;
      sizeQ   <= SZ_B;
      srcImmQ <= 1'b0;
      sextQ   <= 1'b0;
      dstQ    <= '0;
      srcQ    <= '0;
      immLenQ <= '0;
      immCntQ <= '0;
      doneQ   <= 1'b0;
      unsQ    <= 1'b0;
    end else begin
      doneQ <= (state == ST_EX2);
      unsQ  <= 1'b0;
      case (state)
        ST_OPC: begin
          if (accept) begin
            if (!opValid) begin
              unsQ <= 1'b1;
            end else begin
              kindQ   <= opKind;
              sizeQ   <= opSize;
              immCntQ <= '0;
              if (opKind == K_ACC) begin
                dstQ    <= '0;
                srcImmQ <= 1'b1;
                sextQ   <= 1'b0;
                immLenQ <= lenOf(opSize);
                state   <= ST_IMM;
              end else begin
                state <= ST_MODRM;
              end
            end
          end
        end
        ST_MODRM: begin
          if (accept) begin
            if (selBad) begin
              unsQ  <= 1'b1;
              state <= ST_OPC;
            end else begin
              case (kindQ)
                K_GRP: begin
                  dstQ <= selRm; srcImmQ <= 1'b1; sextQ <= 1'b0;
                  immLenQ <= lenOf(sizeQ); state <= ST_IMM;
                end
                K_GRPS: begin
                  dstQ <= selRm; srcImmQ <= 1'b1; sextQ <= 1'b1;
                  immLenQ <= CNT_W'(1); state <= ST_IMM;
                end
                K_TO_RM: begin
                  dstQ <= selRm; srcQ <= selReg; srcImmQ <= 1'b0;
                  state <= ST_EX1;
                end
                default: begin
                  dstQ <= selReg; srcQ <= selRm; srcImmQ <= 1'b0;
                  state <= ST_EX1;
                end
              endcase
            end
          end
        end
        ST_IMM: begin
          if (accept) begin
            immCntQ <= immCntQ + CNT_W'(1);
            if (immCntQ + CNT_W'(1) == immLenQ) state <= ST_EX1;
          end
        end
        ST_EX1:  state <= ST_EX2;
        ST_EX2:  state <= ST_OPC;
        default: state <= ST_OPC;
      endcase
    end
  end

  always_comb begin
    strb.immClr  = (state == ST_OPC) && accept;
    strb.immLoad = (state == ST_IMM) && accept;
    strb.capture = (state == ST_EX1);
    strb.commit  = (state == ST_EX2);
    opd.size     = sizeQ;
    opd.srcImm   = srcImmQ;
    opd.immSext  = sextQ;
    opd.dstSel   = dstQ;
    opd.srcSel   = srcQ;
    opd.immPos   = immCntQ[IMM_IDX_W-1:0];
  end

  assign done        = doneQ;
  assign unsupported = unsQ;
endmodule

// File: rtl/orx_dpath.sv
module orx_dpath
  import orx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  orx_strobe_t       strb,
  input  orx_opd_t          opd,
  input  logic [7:0]        inByte,
  input  logic [RIDX_W-1:0] rdIdx,
  output logic [XLEN-1:0]   rdData,
  output logic [FL_W-1:0]   flags
);
  logic [XLEN-1:0] immQ;
  logic [XLEN-1:0] regView [NREG];
  logic [XLEN-1:0] srcVal;
  logic [XLEN-1:0] dstVal;
  logic [XLEN-1:0] resRaw;
  logic [XLEN-1:0] resMasked;
  logic [XLEN-1:0] widthMask;
  logic [FL_W-1:0] flagsNext;
  logic [XLEN-1:0] resQ;
  logic [FL_W-1:0] flagsNextQ;
  logic [FL_W-1:0] flagsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      immQ <= '0;
    end else if (strb.immClr) begin
      immQ <= '0;
    end else if (strb.immLoad) begin
      immQ[opd.immPos*8 +: 8] <= inByte;
    end
  end

  function automatic logic [XLEN-1:0] readOpd(logic [RIDX_W-1:0] sel, orx_size_e sz);
    logic [RIDX_W-1:0] lowIdx;
    logic [XLEN-1:0]   word;
    lowIdx = {{(RIDX_W-2){1'b0}}, sel[1:0]};
    word   = regView[lowIdx];
    if (sz == SZ_B) begin
      if (sel[2]) return {{(XLEN-8){1'b0}}, word[15:8]};
      else        return {{(XLEN-8){1'b0}}, word[7:0]};
    end
    return regView[sel];
  endfunction

  always_comb begin
    case (opd.size)
      SZ_B:    widthMask = {{(XLEN-8){1'b0}}, 8'hFF};
      SZ_W:    widthMask = {{(XLEN-16){1'b0}}, 16'hFFFF};
      default: widthMask = '1;
    endcase
    if (opd.srcImm) begin
      if (opd.immSext) srcVal = {{(XLEN-8){immQ[7]}}, immQ[7:0]};
      else             srcVal = immQ;
    end else begin
      srcVal = readOpd(opd.srcSel, opd.size);
    end
    dstVal    = readOpd(opd.dstSel, opd.size);
    resRaw    = srcVal | dstVal;
    resMasked = resRaw & widthMask;
  end

  always_comb begin
    flagsNext        = '0;
    flagsNext[FL_ZF] = (resMasked == '0);
    flagsNext[FL_PF] = ~^resMasked[7:0];
    case (opd.size)
      SZ_B:    flagsNext[FL_SF] = resMasked[7];
      SZ_W:    flagsNext[FL_SF] = resMasked[15];
      default: flagsNext[FL_SF] = resMasked[XLEN-1];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ       <= '0;
      flagsNextQ <= '0;
      flagsQ     <= '0;
    end else begin
      if (strb.capture) begin
        resQ       <= resMasked;
        flagsNextQ <= flagsNext;
      end
      if (strb.commit) flagsQ <= flagsNextQ;
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam logic [RIDX_W-1:0] IDX = RIDX_W'(gi);
    logic [XLEN-1:0] regQ;
    logic [XLEN-1:0] regNext;
    logic            byteHit;

    assign byteHit = (opd.dstSel[1:0] == IDX[1:0]) && (IDX[RIDX_W-1:2] == '0);

    always_comb begin
      regNext = regQ;
      case (opd.size)
        SZ_B: if (byteHit) begin
          if (opd.dstSel[2]) regNext[15:8] = resQ[7:0];
          else               regNext[7:0]  = resQ[7:0];
        end
        SZ_W: if (opd.dstSel == IDX) regNext[15:0] = resQ[15:0];
        default: if (opd.dstSel == IDX) regNext = resQ;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            regQ <= '0;
      else if (strb.commit) regQ <= regNext;
    end

    assign regView[gi] = regQ;
  end

  assign rdData = regView[rdIdx];
  assign flags  = flagsQ;
endmodule

// File: rtl/orx_top.sv
module orx_top
  import orx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode32,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  output logic              inReady,
  output logic              done,
  output logic              unsupported,
  input  logic [RIDX_W-1:0] rdIdx,
  output logic [XLEN-1:0]   rdData,
  output logic [FL_W-1:0]   flags
);
  orx_strobe_t strb;
  orx_opd_t    opd;

  orx_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .mode32      (mode32),
    .inValid     (inValid),
    .inByte      (inByte),
    .inReady     (inReady),
    .done        (done),
    .unsupported (unsupported),
    .strb        (strb),
    .opd         (opd)
  );

  orx_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opd    (opd),
    .inByte (inByte),
    .rdIdx  (rdIdx),
    .rdData (rdData),
    .flags  (flags)
  );
endmodule

// File: rtl/orx_checker.sv
module orx_checker
  import orx_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            inReady,
  input logic            done,
  input logic            unsupported,
  input logic [FL_W-1:0] flags
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_NOT_UNSUP: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !unsupported); // R10
  AST_EXEC_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inReady) |=> !inReady ##1 (inReady && done)); // R8
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(flags) |-> done); // R7
  AST_FIXED_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!flags[FL_OF] && !flags[FL_AF] && !flags[FL_CF])); // R7
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(flags[FL_ZF] && flags[FL_SF])); // R7
  AST_REJECT_RESYNC: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> inReady); // R9
endmodule

bind orx_top orx_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inReady     (inReady),
  .done        (done),
  .unsupported (unsupported),
  .flags       (flags)
);

// File: tb/orx_top_bench.sv
`timescale 1ns/1ps
module orx_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mode32 = 1'b1;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        inReady;
  logic        done;
  logic        unsupported;
  logic [2:0]  rdIdx = 3'd0;
  logic [31:0] rdData;
  logic [5:0]  flags;

  orx_top u_orx_top (
    .clk(clk), .rstN(rstN), .mode32(mode32), .inValid(inValid), .inByte(inByte),
    .inReady(inReady), .done(done), .unsupported(unsupported),
    .rdIdx(rdIdx), .rdData(rdData), .flags(flags)
  );

  always #4 clk = ~clk;

  int nCmp = 0;
  int nBad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] progQ[$];

  // behavioural reference state
  logic [31:0] mRegs[8];
  logic [5:0]  mFlags = '0;
  int          mStage = 0;   // 0 opcode, 1 selector, 2 immediate, 3/4 execute
  bit          mReady = 1;
  bit          mDone = 0;
  bit          mUns = 0;
  int          mKind = 0;    // 0 acc, 1 group, 2 group-sext, 3 to-rm, 4 to-reg
  int          mSz = 1;      // bytes
  int          mDst = 0, mSrc = 0, mImmLen = 0, mImmCnt = 0;
  bit          mSrcImm = 0, mSext = 0;
  logic [31:0] mImm = '0;
  string       mPendTag = "R1", mLastTag = "R1";

  initial for (int i = 0; i < 8; i++) mRegs[i] = '0;

  function automatic logic [31:0] szMask(int sz);
    return (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] getOpd(int code, int sz);
    if (sz == 1) return (code < 4) ? {24'h0, mRegs[code][7:0]} : {24'h0, mRegs[code-4][15:8]};
    return mRegs[code] & szMask(sz);
  endfunction

  task automatic modelCommit();
    logic [31:0] a, b, r;
    if (mSrcImm) a = mSext ? {{24{mImm[7]}}, mImm[7:0]} : mImm;
    else         a = getOpd(mSrc, mSz);
    b = getOpd(mDst, mSz);
    r = (a | b) & szMask(mSz);
    if (mSz == 1) begin
      if (mDst < 4) mRegs[mDst][7:0] = r[7:0];
      else          mRegs[mDst-4][15:8] = r[7:0];
    end else if (mSz == 2) mRegs[mDst][15:0] = r[15:0];
    else mRegs[mDst] = r;
    // {OF,SF,ZF,AF,PF,CF}
    mFlags = {1'b0, r[mSz*8-1], (r == 0), 1'b0, ~^r[7:0], 1'b0};
    mLastTag = mPendTag;
  endtask

  task automatic modelByte(logic [7:0] b);
    case (mStage)
      0: begin
        mImm = '0; mImmCnt = 0; mSext = 0;
        mSz = mode32 ? 4 : 2;
        case (b)
          8'h0C: begin mKind = 0; mSz = 1; end
          8'h0D: mKind = 0;
          8'h80: begin mKind = 1; mSz = 1; end
          8'h81: mKind = 1;
          8'h83: mKind = 2;
          8'h08: begin mKind = 3; mSz = 1; end
          8'h09: mKind = 3;
          8'h0A: begin mKind = 4; mSz = 1; end
          8'h0B: mKind = 4;
          default: mKind = -1;
        endcase
        if (mKind < 0) mUns = 1;
        else if (mKind == 0) begin
          mDst = 0; mSrcImm = 1; mImmLen = mSz; mStage = 2; mPendTag = "R2";
        end else mStage = 1;
      end
      1: begin
        if (b[7:6] != 2'b11 || ((mKind == 1 || mKind == 2) && b[5:3] != 3'd1)) begin
          mUns = 1; mStage = 0;
        end else if (mKind == 1 || mKind == 2) begin
          mDst = b[2:0]; mSrcImm = 1; mSext = (mKind == 2);
          mImmLen = (mKind == 2) ? 1 : mSz; mStage = 2;
          mPendTag = (mKind == 2) ? "R4" : "R3";
        end else begin
          mSrcImm = 0;
          if (mKind == 3) begin mDst = b[2:0]; mSrc = b[5:3]; end
          else begin mDst = b[5:3]; mSrc = b[2:0]; end
          mStage = 3;
          mPendTag = (mSz == 1) ? "R6" : "R5";
        end
      end
      default: begin
        mImm[8*mImmCnt +: 8] = b;
        mImmCnt++;
        if (mImmCnt == mImmLen) mStage = 3;
      end
    endcase
  endtask

  always @(posedge clk) begin
    bit acc;
    cyc++;
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mRegs[i] = '0;
      mFlags = '0; mStage = 0; mDone = 0; mUns = 0; mReady = 1;
    end else begin
      acc = inValid && mReady;
      mDone = 0; mUns = 0;
      if (mStage == 4) begin modelCommit(); mStage = 0; mDone = 1; end
      else if (mStage == 3) mStage = 4;
      else if (acc) modelByte(inByte);
      if (acc && progQ.size() > 0) void'(progQ.pop_front());
      mReady = (mStage < 3);
    end
  end

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        cmp("R1", "reset ready", {31'h0, inReady}, 32'h1);
        cmp("R1", "reset done", {31'h0, done}, 32'h0);
        cmp("R1", "reset unsupported", {31'h0, unsupported}, 32'h0);
        cmp("R1", "reset flags", {26'h0, flags}, 32'h0);
        cmp("R1", "reset register", rdData, 32'h0);
      end else begin
        cmp("R8", "ready", {31'h0, inReady}, {31'h0, mReady});
        cmp("R10", "done", {31'h0, done}, {31'h0, mDone});
        cmp("R9", "unsupported", {31'h0, unsupported}, {31'h0, mUns});
        cmp("R7", "flags", {26'h0, flags}, {26'h0, mFlags});
        cmp(mLastTag, $sformatf("reg%0d", rdIdx), rdData, mRegs[rdIdx]);
      end
      rdIdx   <= 3'(cyc % 8);
      inValid <= (progQ.size() > 0) && (cyc % 5 != 3);
      inByte  <= (progQ.size() > 0) ? progQ[0] : 8'h00;
    end
  end

  task automatic push(input logic [7:0] bytes[]);
    foreach (bytes[i]) progQ.push_back(bytes[i]);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    while (progQ.size() != 0 || mStage != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // 32-bit phase
    push('{8'h0C, 8'h81});                                  // R2 byte acc
    push('{8'h0D, 8'h00, 8'h00, 8'h00, 8'h80});             // R2 dword acc
    push('{8'h81, 8'hC9, 8'h34, 8'h12, 8'h00, 8'h00});      // R3 ecx
    push('{8'h80, 8'hCA, 8'h0F});                           // R3 byte dl
    push('{8'h83, 8'hCB, 8'hF0});                           // R4 ebx sext
    push('{8'h83, 8'hCE, 8'h05});                           // R4 esi
    push('{8'h09, 8'hD7});                                  // R5 edi |= edx
    push('{8'h0B, 8'hF8});                                  // R5 edi |= eax
    push('{8'h80, 8'hCC, 8'h5A});                           // R6 high byte ah
    push('{8'h08, 8'hE6});                                  // R6 dh |= ah
    push('{8'h0A, 8'hC4});                                  // R6 al |= ah
    push('{8'hFF, 8'h81, 8'hD1, 8'h09, 8'h01});             // R9 rejects
    push('{8'h80, 8'h41, 8'h0C, 8'h00});                    // R9 memory mode then resync
    push('{8'h81, 8'hCD, 8'h00, 8'h00, 8'h00, 8'h00});      // R7 zero result
    drain();
    @(negedge clk) mode32 = 1'b0;
    // 16-bit phase
    push('{8'h0D, 8'h01, 8'h80});                           // R2 word acc
    push('{8'h83, 8'hCD, 8'hFF});                           // R4 R6 bp
    push('{8'h81, 8'hCE, 8'h00, 8'h01});                    // R3 si
    push('{8'h09, 8'hE9});                                  // R5 cx |= bp
    push('{8'h0B, 8'hDE, 8'h0F, 8'h0A, 8'hFC});             // R5, R9, R6
    drain();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule